// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable, cycle-level model of a single-clock static RAM built for short bursts. Every input is caught in a register on the rising clock edge. An access sequence is opened by one of two address strobes: a processor strobe, which always opens a read, and a controller strobe, which may open a read or a write. The cycles that follow reuse the loaded address. An internal two-bit counter steps the two low address bits, in either linear or interleaved order, while the upper bits stay put. The data word is split into byte lanes. A write can target any subset of lanes, or every lane at once through a global-write input.

Read data leaves through an output register, so it appears two clock edges after the cycle that requested it. The shared data bus is modelled as separate input and output vectors plus a drive-enable. After a deselect, the driver stays on for two more cycles and then turns off. A typical user is a cache or packet-buffer controller that issues one strobe per four-beat line and clocks the rest with the step input.

Top module: `burst_sram`

## Requirements
- R1: Inputs are registered on the rising edge. Read data requested by the inputs captured at edge k is on `dq_out`, with `dq_oe` high, after edge k+2.
- R2: A strobe cycle with the part selected loads `addr` as the burst base, clears the burst count and accesses `addr` itself. With the controller strobe `strb_ctl`, a cycle with no enabled lane is a read and one with enabled lanes is a write.
- R3: On a cycle with no strobe and a burst open, the count advances by one when `burst_step` is 1 and the access uses the new count. When `burst_step` is 0, the same address is accessed again.
- R4: With `order_sel`=0 (linear), the two low address bits are (base low bits + count) mod 4.
- R5: With `order_sel`=1 (interleaved), the two low address bits are the base low bits XOR the count.
- R6: When `wr_all`=0, lane i (`dq_in`/`dq_out` bits [8i+7:8i]) is written only when `lane_wr_en`=1 and `lane_sel[i]`=1. When `lane_wr_en`=0, `lane_sel` has no effect and the cycle is a read.
- R7: With `wr_all`=1, every lane is written, whatever `lane_wr_en` and `lane_sel` hold.
- R8: The part is selected only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0. The select inputs are evaluated on strobe cycles only. A strobe while not selected is a deselect: it closes the burst, and later no-strobe cycles do nothing, writes included.
- R9: `dq_oe` rises with the first read data. A deselect captured at edge k leaves `dq_oe` unchanged after edges k+1 and k+2, and turns it off after edge k+3 unless read data arrives at that edge.
- R10: If both strobes are high, the processor strobe `strb_cpu` wins: the cycle opens a burst as a read and ignores `wr_all`, `lane_wr_en` and `lane_sel`.
- R11: During a burst the address bits above the low two stay at the loaded value, so four-beat bursts wrap inside their aligned group of four.
- R12: During and right after reset `dq_oe` is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External address, loaded on a start |
| dq_in | input | LANES*LANE_W | Write data, inbound half of the shared bus |
| dq_out | output | LANES*LANE_W | Read data, outbound half of the shared bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| strb_cpu | input | 1 | Processor address strobe (read start, has priority) |
| strb_ctl | input | 1 | Controller address strobe (read or write start) |
| burst_step | input | 1 | Advance the burst counter |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| wr_all | input | 1 | Global write of all lanes |
| lane_wr_en | input | 1 | Byte-lane write enable |
| lane_sel | input | LANES | Per-lane write selects |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |

## Verification
A wrong burst counter or order shows up as wrong data on `dq_out` two edges after the faulty beat, because every address in the array holds a distinct value. A wrong lane mask is seen only when the damaged word is read back, which the stimulus does within a few bursts. A fault in the deselect pipeline shows as `dq_oe` one cycle early or late, right on the third edge after the deselect.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_DESEL = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/bsr_in_reg.sv
module bsr_in_reg #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic                    strb_cpu,
    input  logic                    strb_ctl,
    input  logic                    burst_step,
    input  logic                    order_sel,
    input  logic                    wr_all,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic                    sel_a,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    output logic [ADDR_W-1:0]       q_addr,
    output logic [LANES*LANE_W-1:0] q_data,
    output logic                    q_cpu,
    output logic                    q_ctl,
    output logic                    q_step,
    output logic                    q_order,
    output logic                    q_all,
    output logic                    q_lwe,
    output logic [LANES-1:0]        q_lsel,
    output logic                    q_sel
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic              cpu;
        logic              ctl;
        logic              step;
        logic              order;
        logic              all;
        logic              lwe;
        logic [LANES-1:0]  lsel;
        logic              sel;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.addr  = addr;
        cap_d.data  = dq_in;
        cap_d.cpu   = strb_cpu;
        cap_d.ctl   = strb_ctl;
        cap_d.step  = burst_step;
        cap_d.order = order_sel;
        cap_d.all   = wr_all;
        cap_d.lwe   = lane_wr_en;
        cap_d.lsel  = lane_sel;
        cap_d.sel   = sel_a & sel_b & ~sel_c_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign q_addr  = cap_q.addr;
    assign q_data  = cap_q.data;
    assign q_cpu   = cap_q.cpu;
    assign q_ctl   = cap_q.ctl;
    assign q_step  = cap_q.step;
    assign q_order = cap_q.order;
    assign q_all   = cap_q.all;
    assign q_lwe   = cap_q.lwe;
    assign q_lsel  = cap_q.lsel;
    assign q_sel   = cap_q.sel;
endmodule

// File: rtl/bsr_burst_ctrl.sv
module bsr_burst_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic              q_cpu,
    input  logic              q_ctl,
    input  logic              q_step,
    input  logic              q_order,
    input  logic              q_all,
    input  logic              q_lwe,
    input  logic [LANES-1:0]  q_lsel,
    input  logic              q_sel,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  wr_mask
);
    typedef struct packed {
        logic              open;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } bst_t;

    bst_t bst_d, bst_q;
    logic [LANES-1:0] lanes;
    logic             strobe;
    logic [1:0]       cnt_n;
    logic [1:0]       low_n;

    always_comb begin
        bst_d    = bst_q;
        kind     = K_NONE;
        acc_addr = bst_q.base;
        wr_mask  = '0;
        strobe   = q_cpu | q_ctl;
        lanes    = q_all ? '1 : (q_lwe ? q_lsel : '0);
        cnt_n    = bst_q.cnt + {1'b0, q_step};
        low_n    = q_order ? (bst_q.base[1:0] ^ cnt_n)
                           : (bst_q.base[1:0] + cnt_n);
        if (strobe && q_sel) begin
            bst_d.open = 1'b1;
            bst_d.base = q_addr;
            bst_d.cnt  = 2'd0;
            acc_addr   = q_addr;
            wr_mask    = q_cpu ? '0 : lanes;
            kind       = (|wr_mask) ? K_WRITE : K_READ;
        end else if (strobe) begin
            bst_d.open = 1'b0;
            kind       = K_DESEL;
        end else if (bst_q.open) begin
            bst_d.cnt = cnt_n;
            acc_addr  = {bst_q.base[ADDR_W-1:2], low_n};
            wr_mask   = lanes;
            kind      = (|lanes) ? K_WRITE : K_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bst_q <= '0;
        else        bst_q <= bst_d;
    end
endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  acc_kind_e               kind,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] rd_addr_d, rd_addr_q;

    always_comb begin
        rd_addr_d = (kind == K_READ) ? acc_addr : rd_addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_addr_q <= '0;
        else        rd_addr_q <= rd_addr_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g]) lane_mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[rd_addr_q];
    end
endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage
    import burst_sram_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_kind_e     kind_s1,
    input  logic [DW-1:0] rdata,
    output acc_kind_e     kind_s2,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    typedef struct packed {
        acc_kind_e     s2;
        acc_kind_e     s3;
        logic [DW-1:0] dout;
        logic          oe;
    } os_t;

    os_t os_d, os_q;

    always_comb begin
        os_d    = os_q;
        os_d.s2 = kind_s1;
        os_d.s3 = os_q.s2;
        if (os_q.s2 == K_READ) begin
            os_d.dout = rdata;
            os_d.oe   = 1'b1;
        end else if (os_q.s3 == K_DESEL) begin
            os_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= '{s2: K_NONE, s3: K_NONE, dout: '0, oe: 1'b0};
        else        os_q <= os_d;
    end

    assign kind_s2 = os_q.s2;
    assign dq_out  = os_q.dout;
    assign dq_oe   = os_q.oe;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe,
    input  logic                    strb_cpu,
    input  logic                    strb_ctl,
    input  logic                    burst_step,
    input  logic                    order_sel,
    input  logic                    wr_all,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic                    sel_a,
    input  logic                    sel_b,
    input  logic                    sel_c_n
);
    localparam int DW = LANES * LANE_W;

    logic [ADDR_W-1:0] q_addr;
    logic [DW-1:0]     q_data;
    logic              q_cpu, q_ctl, q_step, q_order, q_all, q_lwe, q_sel;
    logic [LANES-1:0]  q_lsel;
    acc_kind_e         kind_s1, kind_s2;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  wr_mask;
    logic [DW-1:0]     rdata;

    bsr_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_in_reg (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in),
        .strb_cpu(strb_cpu), .strb_ctl(strb_ctl), .burst_step(burst_step),
        .order_sel(order_sel), .wr_all(wr_all), .lane_wr_en(lane_wr_en),
        .lane_sel(lane_sel), .sel_a(sel_a), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .q_addr(q_addr), .q_data(q_data), .q_cpu(q_cpu), .q_ctl(q_ctl),
        .q_step(q_step), .q_order(q_order), .q_all(q_all), .q_lwe(q_lwe),
        .q_lsel(q_lsel), .q_sel(q_sel)
    );

    bsr_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .q_addr(q_addr), .q_cpu(q_cpu),
        .q_ctl(q_ctl), .q_step(q_step), .q_order(q_order), .q_all(q_all),
        .q_lwe(q_lwe), .q_lsel(q_lsel), .q_sel(q_sel),
        .kind(kind_s1), .acc_addr(acc_addr), .wr_mask(wr_mask)
    );

    bsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk(clk), .rst_n(rst_n), .kind(kind_s1), .acc_addr(acc_addr),
        .wr_mask(wr_mask), .wdata(q_data), .rdata(rdata)
    );

    bsr_out_stage #(.DW(DW)) i_out (
        .clk(clk), .rst_n(rst_n), .kind_s1(kind_s1), .rdata(rdata),
        .kind_s2(kind_s2), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_cpu,
    input logic              q_ctl,
    input logic              q_all,
    input logic              q_lwe,
    input logic              q_sel,
    input acc_kind_e         kind_s1,
    input acc_kind_e         kind_s2,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [LANES-1:0]  wr_mask,
    input logic              dq_oe
);
    logic cont;
    assign cont = !q_cpu && !q_ctl && (kind_s1 == K_READ || kind_s1 == K_WRITE);

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (!dq_oe); // R12
    end

    AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (q_all && q_ctl && !q_cpu && q_sel) |-> (&wr_mask)); // R7

    AST_NO_ENABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_all && !q_lwe) |-> (wr_mask == '0)); // R6

    AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cpu && q_sel) |-> (kind_s1 == K_READ)); // R10

    AST_DRIVE_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_s2 == K_READ) |=> dq_oe); // R9

    AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_s1 == K_DESEL) |=> (q_cpu || q_ctl || kind_s1 == K_NONE)); // R8

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && $past(cont) && $past(rst_n)) |->
        (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]))); // R11
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
    .clk(clk), .rst_n(rst_n), .q_cpu(q_cpu), .q_ctl(q_ctl), .q_all(q_all),
    .q_lwe(q_lwe), .q_sel(q_sel), .kind_s1(kind_s1), .kind_s2(kind_s2),
    .acc_addr(acc_addr), .wr_mask(wr_mask), .dq_oe(dq_oe)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
    import burst_sram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int NL    = 4;
    localparam int LW    = 8;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;
    localparam int MAXC  = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          strb_cpu = 1'b0, strb_ctl = 1'b0, burst_step = 1'b0, order_sel = 1'b0;
    logic          wr_all = 1'b0, lane_wr_en = 1'b0;
    logic [NL-1:0] lane_sel = '0;
    logic          sel_a = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
        .burst_step(burst_step), .order_sel(order_sel), .wr_all(wr_all),
        .lane_wr_en(lane_wr_en), .lane_sel(lane_sel), .sel_a(sel_a),
        .sel_b(sel_b), .sel_c_n(sel_c_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int        n_checks = 0;
    int        n_err = 0;
    int        e = 0;
    string     cur_req = "R12";
    logic [DW-1:0] ref_mem [DEPTH];
    acc_kind_e kind_h [MAXC];
    logic      en_h [MAXC];
    logic [DW-1:0] dat_h [MAXC];
    bit        m_open = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, e, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(int a, int salt);
        return {8'(a * 7 + salt), 8'(a + 8'h40), 8'(salt * 3 + 1), 8'(a ^ 8'h5a)};
    endfunction

    task automatic model(logic sp, logic sc, logic stp, logic ord, logic gall,
                         logic lwe, logic [NL-1:0] ls, logic [AW-1:0] a,
                         logic [DW-1:0] d, logic sa, logic sb, logic scn);
        logic          sel = sa & sb & ~scn;
        logic [NL-1:0] lanes = gall ? '1 : (lwe ? ls : '0);
        logic [NL-1:0] wrm = '0;
        logic [AW-1:0] acc = '0;
        acc_kind_e     k = K_NONE;
        if ((sp || sc) && sel) begin
            m_open = 1; m_base = a; m_cnt = 0; acc = a;
            wrm = sp ? '0 : lanes;
            k = (wrm != 0) ? K_WRITE : K_READ;
        end else if (sp || sc) begin
            m_open = 0; k = K_DESEL;
        end else if (m_open) begin
            if (stp) m_cnt = m_cnt + 2'd1;
            acc = {m_base[AW-1:2], ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            wrm = lanes;
            k = (wrm != 0) ? K_WRITE : K_READ;
        end
        kind_h[e] = k;
        if (k == K_READ) begin
            en_h[e+2]  = 1'b1;
            dat_h[e+2] = ref_mem[acc];
        end else begin
            en_h[e+2]  = (e >= 1 && kind_h[e-1] == K_DESEL) ? 1'b0 : en_h[e+1];
            dat_h[e+2] = dat_h[e+1];
        end
        for (int i = 0; i < NL; i++)
            if (wrm[i]) ref_mem[acc][i*LW +: LW] = d[i*LW +: LW];
    endtask

    task automatic cyc(logic sp, logic sc, logic stp, logic ord, logic gall,
                       logic lwe, logic [NL-1:0] ls, logic [AW-1:0] a,
                       logic [DW-1:0] d, logic sa = 1, logic sb = 1, logic scn = 0);
        @(negedge clk);
        if (e >= 1) begin
            check(cur_req, "dq_oe", DW'(dq_oe), DW'(en_h[e]));
            if (en_h[e]) check(cur_req, "dq_out", dq_out, dat_h[e]);
        end
        strb_cpu = sp; strb_ctl = sc; burst_step = stp; order_sel = ord;
        wr_all = gall; lane_wr_en = lwe; lane_sel = ls; addr = a; dq_in = d;
        sel_a = sa; sel_b = sb; sel_c_n = scn;
        @(posedge clk);
        e++;
        model(sp, sc, stp, ord, gall, lwe, ls, a, d, sa, sb, scn);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, '0, '0, '0);
    endtask

    task automatic read_burst(logic cpu, logic [AW-1:0] a, logic ord, logic [3:0] steps);
        cyc(cpu, !cpu, 0, ord, 0, 0, '0, a, '0);
        for (int i = 0; i < 3; i++) cyc(0, 0, steps[i], ord, 0, 0, '0, '0, '0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        for (int i = 0; i < MAXC; i++) begin
            kind_h[i] = K_NONE; en_h[i] = 1'b0; dat_h[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        seed = $urandom(32'd20240611);

        // R12: held in reset, driver off
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "dq_oe in reset", DW'(dq_oe), '0);
        rst_n = 1'b1;

        // R7 and R4: fill every word with global-write linear bursts
        cur_req = "R7";
        for (int b = 0; b < DEPTH / 4; b++) begin
            cyc(0, 1, 0, 0, 1, 0, '0, AW'(b * 4), pattern(b * 4, 1));
            for (int j = 1; j < 4; j++)
                cyc(0, 0, 1, 0, 1, 0, 4'h0, '0, pattern(b * 4 + j, 1));
        end
        idle(2);

        // R4: linear burst from an unaligned start wraps inside its group
        cur_req = "R4";
        read_burst(1, 6'd22, 0, 4'b111);
        // R5: interleaved order from low bits 01 and 10
        cur_req = "R5";
        read_burst(1, 6'd13, 1, 4'b111);
        read_burst(0, 6'd46, 1, 4'b111);
        // R3: hold the counter on some beats
        cur_req = "R3";
        read_burst(1, 6'd33, 0, 4'b010);
        // R11: top group wraps without leaving it
        cur_req = "R11";
        read_burst(1, 6'd63, 0, 4'b111);
        // R2: controller strobe write then read back
        cur_req = "R2";
        cyc(0, 1, 0, 0, 0, 1, 4'b1111, 6'd5, 32'hdead_beef);
        read_burst(0, 6'd5, 0, 4'b000);
        // R6: partial lanes, then selects without enable
        cur_req = "R6";
        cyc(0, 1, 0, 0, 0, 1, 4'b0101, 6'd9, 32'h1122_3344);
        cyc(0, 0, 1, 0, 0, 1, 4'b1010, '0, 32'h5566_7788);
        cyc(0, 0, 1, 0, 0, 0, 4'b1111, '0, 32'h99aa_bbcc);
        read_burst(1, 6'd9, 0, 4'b111);
        // R10: both strobes with write controls is a read
        cur_req = "R10";
        cyc(1, 1, 0, 0, 1, 1, 4'b1111, 6'd17, 32'h0bad_0bad);
        idle(1);
        read_burst(1, 6'd17, 0, 4'b000);
        // R8: unselected strobe closes burst, later writes are dropped
        cur_req = "R8";
        cyc(1, 0, 0, 0, 0, 0, '0, 6'd40, '0);
        cyc(0, 1, 0, 0, 1, 0, '0, 6'd40, 32'hffff_0000, 1, 1, 1);
        cyc(0, 0, 1, 0, 1, 0, '0, '0, 32'h1234_5678);
        cyc(0, 1, 0, 0, 1, 0, '0, 6'd41, 32'h0, 0, 1, 0);
        idle(3);
        read_burst(1, 6'd40, 0, 4'b111);
        // R9: read, deselect, then quiet cycles; then read right after deselect
        cur_req = "R9";
        cyc(1, 0, 0, 0, 0, 0, '0, 6'd50, '0);
        cyc(0, 1, 0, 0, 0, 0, '0, '0, '0, 0, 0, 1);
        idle(5);
        cyc(1, 0, 0, 0, 0, 0, '0, 6'd51, '0);
        cyc(1, 0, 0, 0, 0, 0, '0, '0, '0, 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, '0, 6'd52, '0);
        idle(5);

        // R1: mixed random traffic
        cur_req = "R1";
        for (int i = 0; i < 1500; i++) begin
            int r = $urandom_range(0, 99);
            logic sp = (r < 10);
            logic sc = (r >= 8 && r < 22);
            logic desel = ($urandom_range(0, 9) == 0);
            cyc(sp, sc, 1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
                1'($urandom), 4'($urandom), 6'($urandom), $urandom,
                desel ? 1'($urandom) : 1'b1, desel ? 1'($urandom) : 1'b1,
                desel ? 1'($urandom) : 1'b0);
        end
        idle(4);
        finish_run();
    end
endmodule